// File: doc/BRIEF.md
# Contiguous Packet Framing Checker

This block watches one direction of a word-wide link, where a single valid strobe qualifies each 32-bit word. It finds the packet boundaries and checks that each packet arrives without breaks. A packet opens on the first valid word seen while the checker is idle. That word is the header. Its low four bits give the index of the final word, so the packet is that field plus one words long, from 1 to 16 words. Every later word of the packet must follow on the very next cycle. There is no separate end strobe. The sender ends the packet by dropping valid right after the final word. The same rules hold for either link direction, so one checker can serve both.

Each accepted word is forwarded one cycle later, marked with a start flag on the header and an end flag on the final word. A break in the flow before the final word is a sequence fault. So is a word that arrives while valid should already have fallen. Either fault gives a one-cycle error pulse. After an overrun, the checker drops every word until valid has been low for a cycle, then waits for the next packet.

The controller has four states. FK_IDLE waits for a header. FK_BODY collects the words after the header. FK_TAIL expects valid to fall after the final word. FK_DROP discards words after an overrun. The transitions are:
- idle-to-body: a header whose field is nonzero.
- idle-to-tail: a header whose field is zero.
- body-to-body: a word that is not the final one.
- body-to-tail: the final word.
- body-to-idle: a gap fault.
- tail-to-idle: a clean end.
- tail-to-drop: an overrun fault.
- drop-to-idle: valid is low.

Top module: `pkt_frame_chk`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_sop, out_eop and out_err are 0 and the checker is idle.
- R2: A valid word received while idle is a header. It appears on out_data one cycle later with out_valid=1 and out_sop=1. The expected length is header bits [3:0] plus one.
- R3: Each following word that arrives with valid high on the next cycle is forwarded unchanged one cycle later, with out_valid=1 and out_sop=0.
- R4: out_eop=1 comes with the final word, which is word number length (1 to 16). A one-word packet carries out_sop=1 and out_eop=1 together.
- R5: If valid is low before the final word, out_err pulses for exactly one cycle, one cycle after the gap, with out_valid=0.
- R6: If valid is still high on the cycle after the final word, out_err pulses one cycle later, and that word is not forwarded.
- R7: After an overrun, words are neither forwarded nor flagged until valid has been low for one cycle. The next valid word then opens a new packet with out_sop=1.
- R8: After a gap fault, the next valid word opens a new packet with out_sop=1.
- R9: out_err never coincides with out_valid. out_sop and out_eop are only set together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word qualifier on the link |
| in_data | input | 32 | Incoming word |
| out_valid | output | 1 | Forwarded word is valid |
| out_data | output | 32 | Forwarded word |
| out_sop | output | 1 | Forwarded word is a header |
| out_eop | output | 1 | Forwarded word is the final word |
| out_err | output | 1 | One-cycle sequence fault pulse |

## Verification
Every result passes through exactly one register, so forwarded words, markers and fault pulses all appear one cycle after the input cycle that caused them. The bench drives each input on a falling edge and lets one rising edge pass. It compares the outputs on the following falling edge, which pairs each table row's expected outputs with that row's own stimulus. The reset check samples while reset is held and again on the first cycle after release.

// File: rtl/fk_pkg.sv
package fk_pkg;

    typedef enum logic [1:0] {
        FK_IDLE,
        FK_BODY,
        FK_TAIL,
        FK_DROP
    } fk_state_t;

endpackage

// File: rtl/fk_len_decode.sv
module fk_len_decode #(
    parameter int LEN_W = 4
) (
    input  logic [LEN_W-1:0] field_i,
    output logic [LEN_W-1:0] last_idx_o,
    output logic             single_o
);

    // The header field holds the index of the final word (length minus one).
    always_comb begin
        last_idx_o = field_i;
        single_o   = (field_i == '0);
    end

endmodule

// File: rtl/fk_word_counter.sv
module fk_word_counter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] lim_i,
    input  logic             step_i,
    output logic             at_last_o
);

    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            idx_q <= LEN_W'(1);
            lim_q <= lim_i;
        end else if (step_i) begin
            idx_q <= idx_q + LEN_W'(1);
        end
    end

    always_comb at_last_o = (idx_q == lim_q);

    // R4: a body word is never counted past the final index
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (idx_q <= lim_q));

endmodule

// File: rtl/fk_ctrl.sv
module fk_ctrl
    import fk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid_i,
    input  logic      single_i,
    input  logic      at_last_i,
    output fk_state_t state_o,
    output logic      take_hdr_o,
    output logic      take_word_o,
    output logic      last_o,
    output logic      fault_o
);

    fk_state_t state_q;
    fk_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        take_hdr_o  = 1'b0;
        take_word_o = 1'b0;
        last_o      = 1'b0;
        fault_o     = 1'b0;
        unique case (state_q)
            FK_IDLE: begin
                if (valid_i) begin
                    take_hdr_o = 1'b1;
                    last_o     = single_i;
                    state_d    = single_i ? FK_TAIL : FK_BODY;
                end
            end
            FK_BODY: begin
                if (valid_i) begin
                    take_word_o = 1'b1;
                    last_o      = at_last_i;
                    state_d     = at_last_i ? FK_TAIL : FK_BODY;
                end else begin
                    fault_o = 1'b1;
                    state_d = FK_IDLE;
                end
            end
            FK_TAIL: begin
                if (valid_i) begin
                    fault_o = 1'b1;
                    state_d = FK_DROP;
                end else begin
                    state_d = FK_IDLE;
                end
            end
            FK_DROP: begin
                if (!valid_i) state_d = FK_IDLE;
            end
            default: state_d = FK_IDLE;
        endcase
    end

    always_comb state_o = state_q;

    // R7: a discarded word never leaves the drop state
    assert_drop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FK_DROP && valid_i) |=> (state_q == FK_DROP));

endmodule

// File: rtl/pkt_frame_chk.sv
module pkt_frame_chk
    import fk_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LEN_LSB = 0,
    parameter int LEN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err
);

    logic [LEN_W-1:0] last_idx;
    logic             single;
    logic             at_last;
    fk_state_t        st;
    logic             take_hdr;
    logic             take_word;
    logic             is_last;
    logic             fault;

    fk_len_decode #(.LEN_W(LEN_W)) u_dec (
        .field_i    (in_data[LEN_LSB +: LEN_W]),
        .last_idx_o (last_idx),
        .single_o   (single)
    );

    fk_word_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (take_hdr),
        .lim_i     (last_idx),
        .step_i    (take_word),
        .at_last_o (at_last)
    );

    fk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (in_valid),
        .single_i    (single),
        .at_last_i   (at_last),
        .state_o     (st),
        .take_hdr_o  (take_hdr),
        .take_word_o (take_word),
        .last_o      (is_last),
        .fault_o     (fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= take_hdr | take_word;
            out_sop   <= take_hdr;
            out_eop   <= (take_hdr | take_word) & is_last;
            out_err   <= fault;
            if (take_hdr | take_word) out_data <= in_data;
        end
    end

    // R9: a fault pulse never carries data
    assert_err_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !out_valid);

    // R9: markers only on forwarded words
    assert_marker_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    // R5: the fault indication lasts one cycle
    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |=> !out_err);

    // R5: a gap inside a packet is flagged on the next cycle
    assert_gap_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FK_BODY && !in_valid) |=> out_err);

    // R3: body words are forwarded unchanged a cycle later
    assert_body_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FK_BODY && in_valid) |=> (out_valid && !out_sop && out_data == $past(in_data)));

    // R6: a word after the final one is a fault and is not forwarded
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FK_TAIL && in_valid) |=> (out_err && !out_valid));

    // R7: discarded words are silent
    assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FK_DROP && in_valid) |=> (!out_valid && !out_err));

endmodule

// File: tb/pkt_frame_chk_bench.sv
module pkt_frame_chk_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 24;

    // {req[3:0], valid, data[31:0], exp_valid, exp_sop, exp_eop, exp_err}
    localparam logic [40:0] VECS [NVEC] = '{
        {4'd1, 1'b0, 32'h00000000, 4'b0000}, // R1 idle
        {4'd2, 1'b1, 32'hA0000002, 4'b1100}, // R2 header, length 3
        {4'd3, 1'b1, 32'h11111111, 4'b1000}, // R3
        {4'd4, 1'b1, 32'h22222222, 4'b1010}, // R4 final word
        {4'd3, 1'b0, 32'h00000000, 4'b0000}, // clean end
        {4'd4, 1'b1, 32'hB0000000, 4'b1110}, // R4 single word
        {4'd4, 1'b0, 32'h00000000, 4'b0000},
        {4'd2, 1'b1, 32'hC0000003, 4'b1100}, // header, length 4
        {4'd3, 1'b1, 32'h33333333, 4'b1000},
        {4'd5, 1'b0, 32'h00000000, 4'b0001}, // R5 gap fault
        {4'd8, 1'b1, 32'hD0000001, 4'b1100}, // R8 resync after gap
        {4'd4, 1'b1, 32'h44444444, 4'b1010},
        {4'd4, 1'b0, 32'h00000000, 4'b0000},
        {4'd2, 1'b1, 32'hE0000001, 4'b1100},
        {4'd4, 1'b1, 32'h55555555, 4'b1010},
        {4'd6, 1'b1, 32'h66666666, 4'b0001}, // R6 overrun
        {4'd7, 1'b1, 32'h77777777, 4'b0000}, // R7 discard
        {4'd7, 1'b1, 32'h8000000F, 4'b0000}, // R7 discard header-like word
        {4'd7, 1'b0, 32'h00000000, 4'b0000},
        {4'd7, 1'b1, 32'hF0000000, 4'b1110}, // R7 new packet
        {4'd7, 1'b0, 32'h00000000, 4'b0000},
        {4'd2, 1'b1, 32'h90000002, 4'b1100},
        {4'd5, 1'b0, 32'h00000000, 4'b0001}, // R5 gap on first body word
        {4'd5, 1'b0, 32'h00000000, 4'b0000}  // R5 single pulse
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pkt_frame_chk u_pkt_frame_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_err)
    );

    task automatic check(input int req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: {v,sop,eop,err,data} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [31:0] d);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [35:0] outs();
        return {out_valid, out_sop, out_eop, out_err, out_data};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_data;
        repeat (2) @(negedge clk);
        // R1: outputs cleared during reset
        check(1, outs(), 36'h0);
        rst_n = 1'b1;
        last_data = '0;

        for (int i = 0; i < NVEC; i++) begin
            cycle(VECS[i][36], VECS[i][35:4]);
            if (VECS[i][3]) last_data = VECS[i][35:4];
            check(int'(VECS[i][40:37]), outs(), {VECS[i][3:0], last_data});
        end

        // R4: longest packet, 16 words, end flag only on the 16th
        cycle(1'b1, 32'h1234567F);
        check(4, outs(), {4'b1100, 32'h1234567F});
        for (int k = 1; k < 16; k++) begin
            cycle(1'b1, 32'h5A000000 + k);
            check(4, outs(), {1'b1, 1'b0, (k == 15), 1'b0, 32'h5A000000 + k});
        end
        cycle(1'b0, 32'h0);
        check(4, outs(), {4'b0000, 32'h5A00000F});

        // R1: reset in the middle of a packet
        cycle(1'b1, 32'h20000003);
        cycle(1'b1, 32'h21212121);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, outs(), 36'h0);
        rst_n = 1'b1;
        cycle(1'b0, 32'h0);
        check(1, outs(), 36'h0);
        // R2: fresh header after reset opens a packet
        cycle(1'b1, 32'h30000000);
        check(2, outs(), {4'b1110, 32'h30000000});
        cycle(1'b0, 32'h0);
        check(9, outs(), {4'b0000, 32'h30000000}); // R9 quiet after end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule